// File: doc/BRIEF.md
# Dual Priority Request Encoder

This block looks at eight request lines at once and names two of them: the asserted line with the highest priority, and the asserted line that would win if the first one were absent. Line 7 has the highest priority and line 0 the lowest. Each of the two indices has its own valid flag, so a consumer can grant two requesters per decision without running a second lookup.

The block is purely combinational and has no clock, no reset and no handshake. Its outputs follow the request vector within the same evaluation. The second result comes from a copy of the first encoder. That copy is fed with the request vector after the first winner's line has been cleared by a one-hot decoder.

Top module: `dual_prio_enc`

## Requirements
- R1: `top_vld_o` is 1 exactly when at least one bit of `req_i` is 1.
- R2: When `top_vld_o` is 1, `top_idx_o` is the largest bit position n for which `req_i[n]` is 1 (bit 7 has the highest priority).
- R3: `next_vld_o` is 1 exactly when two or more bits of `req_i` are 1.
- R4: When `next_vld_o` is 1, `next_idx_o` is the largest bit position of `req_i` that is 1 once position `top_idx_o` is excluded.
- R5: When `top_vld_o` is 0, `top_idx_o` is 3'd0.
- R6: When `next_vld_o` is 0, `next_idx_o` is 3'd0.
- R7: With exactly one bit of `req_i` set, `top_idx_o` gives that bit's position and `next_vld_o` is 0.
- R8: Whenever `next_vld_o` is 1, `next_idx_o` is strictly less than `top_idx_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | 8 | Request lines; bit 7 highest priority, bit 0 lowest |
| top_idx_o | output | 3 | Position of the highest-priority asserted request |
| top_vld_o | output | 1 | At least one request is asserted |
| next_idx_o | output | 3 | Position of the runner-up asserted request |
| next_vld_o | output | 1 | Two or more requests are asserted |

## Verification
The first and second winners are always resolved from the same request vector in the same evaluation. The most revealing case is two adjacent lines asserted together, such as 7 with 6 or 1 with 0, because a mistake in clearing the first winner then shows up directly as a wrong runner-up. All 256 patterns are applied, followed by seeded random vectors and directed single-bit and adjacent-pair cases. Each result is compared with a loop-based reference that finds the top bit, removes it and searches again.

// File: rtl/dpe_pkg.sv
package dpe_pkg;
  localparam int unsigned REQ_W = 8;
  localparam int unsigned IDX_W = $clog2(REQ_W);

  typedef logic [REQ_W-1:0] req_vec_t;
  typedef logic [IDX_W-1:0] req_idx_t;

  typedef struct packed {
    logic     vld;
    req_idx_t idx;
  } pick_t;
endpackage

// File: rtl/dpe_pick_top.sv
module dpe_pick_top #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [IW-1:0]    idx_o,
  output logic             vld_o
);
  // Scan upward; a later (higher) set bit overrides an earlier one.
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < int'(WIDTH); i++) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign vld_o = |vec_i;

  always_comb begin
    if (!$isunknown(vec_i)) begin
      AST_PICK_IS_SET: assert (!vld_o || vec_i[idx_o])
        else $error("picked bit not set"); // R2
      AST_PICK_IDLE_ZERO: assert (vld_o || idx_o == '0)
        else $error("idle index not zero"); // R5
    end
  end
endmodule

// File: rtl/dpe_strip.sv
module dpe_strip #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vec_i,
  input  logic [IW-1:0]    idx_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] vec_o
);
  logic [WIDTH-1:0] hit;

  // One-hot decode of the winner, then clear it from the vector.
  for (genvar g = 0; g < int'(WIDTH); g++) begin : g_dec
    assign hit[g]   = en_i && (idx_i == IW'(g));
    assign vec_o[g] = vec_i[g] & ~hit[g];
  end

  always_comb begin
    if (!$isunknown({vec_i, idx_i, en_i})) begin
      AST_STRIP_ONE_BIT: assert (!en_i || !vec_i[idx_i] ||
                                 $countones(vec_o) + 1 == $countones(vec_i))
        else $error("strip removed wrong number of bits"); // R4
    end
  end
endmodule

// File: rtl/dual_prio_enc.sv
module dual_prio_enc
  import dpe_pkg::*;
(
  input  logic [7:0] req_i,
  output logic [2:0] top_idx_o,
  output logic       top_vld_o,
  output logic [2:0] next_idx_o,
  output logic       next_vld_o
);
  pick_t    first_p, second_p;
  req_vec_t rest;

  dpe_pick_top #(.WIDTH(REQ_W)) u_first (
    .vec_i (req_i),
    .idx_o (first_p.idx),
    .vld_o (first_p.vld)
  );

  dpe_strip #(.WIDTH(REQ_W)) u_strip (
    .vec_i (req_i),
    .idx_i (first_p.idx),
    .en_i  (first_p.vld),
    .vec_o (rest)
  );

  dpe_pick_top #(.WIDTH(REQ_W)) u_second (
    .vec_i (rest),
    .idx_o (second_p.idx),
    .vld_o (second_p.vld)
  );

  assign top_idx_o  = first_p.idx;
  assign top_vld_o  = first_p.vld;
  assign next_idx_o = second_p.idx;
  assign next_vld_o = second_p.vld;

  always_comb begin
    if (!$isunknown(req_i)) begin
      AST_TOP_VLD_ANY: assert (top_vld_o == (req_i != '0))
        else $error("top valid mismatch"); // R1
      AST_TOP_NOTHING_ABOVE: assert (!top_vld_o || (req_i >> top_idx_o) == 8'd1)
        else $error("higher request ignored"); // R2
      AST_NEXT_VLD_COUNT: assert (next_vld_o == ($countones(req_i) >= 2))
        else $error("next valid mismatch"); // R3
      AST_NEXT_IS_SET: assert (!next_vld_o || req_i[next_idx_o])
        else $error("runner-up not a request"); // R4
      AST_NEXT_IDLE_ZERO: assert (next_vld_o || next_idx_o == 3'd0)
        else $error("runner-up index not zero"); // R6
      AST_SINGLE_NO_NEXT: assert ($countones(req_i) != 1 || !next_vld_o)
        else $error("single request gave runner-up"); // R7
      AST_NEXT_BELOW_TOP: assert (!next_vld_o || next_idx_o < top_idx_o)
        else $error("runner-up not below winner"); // R8
    end
  end
endmodule

// File: tb/dual_prio_enc_bench.sv
module dual_prio_enc_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic [7:0] req;
  logic [2:0] top_idx, next_idx;
  logic       top_vld, next_vld;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_prio_enc u_dual_prio_enc (
    .req_i      (req),
    .top_idx_o  (top_idx),
    .top_vld_o  (top_vld),
    .next_idx_o (next_idx),
    .next_vld_o (next_vld)
  );

  // Reference: find top bit, remove it, search again.
  function automatic logic [7:0] ref_pair(input logic [7:0] r);
    logic [2:0] a, b;
    logic       va, vb;
    logic [7:0] m;
    a = 3'd0; va = 1'b0; b = 3'd0; vb = 1'b0;
    for (int i = 7; i >= 0; i--) if (!va && r[i]) begin a = 3'(i); va = 1'b1; end
    m = r;
    if (va) m[a] = 1'b0;
    for (int i = 7; i >= 0; i--) if (!vb && m[i]) begin b = 3'(i); vb = 1'b1; end
    return {va, a, vb, b};
  endfunction

  task automatic chk(input string tag, input logic [7:0] pat,
                     input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s req=%08b actual=%0h expected=%0h", tag, pat, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] pat);
    logic [7:0] e;
    @(posedge clk);
    req = pat;
    @(negedge clk);
    e = ref_pair(pat);
    chk("R1", pat, {3'd0, top_vld},  {3'd0, e[7]});
    chk("R3", pat, {3'd0, next_vld}, {3'd0, e[3]});
    if (e[7]) chk("R2", pat, {1'b0, top_idx},  {1'b0, e[6:4]});
    else      chk("R5", pat, {1'b0, top_idx},  4'd0);
    if (e[3]) chk("R4", pat, {1'b0, next_idx}, {1'b0, e[2:0]});
    else      chk("R6", pat, {1'b0, next_idx}, 4'd0);
    if ($countones(pat) == 1)
      chk("R7", pat, {top_vld, top_idx}, {1'b1, e[6:4]});
    if (next_vld)
      chk("R8", pat, {3'd0, next_idx < top_idx}, 4'd1);
  endtask

  initial begin
    req = 8'h00;
    @(negedge clk);
    chk("R1", req, {top_vld, top_idx}, 4'd0);      // idle state
    chk("R6", req, {next_vld, next_idx}, 4'd0);
    for (int p = 0; p < 256; p++) apply(8'(p));
    for (int k = 0; k < 8; k++) apply(8'(1 << k));  // R7 singles
    for (int k = 0; k < 7; k++) apply(8'(3 << k));  // adjacent pairs, R4
    apply(8'hFF);
    apply(8'h81);
    void'($urandom(32'd2024));
    for (int k = 0; k < 300; k++) apply(8'($urandom));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule